// File: doc/BRIEF.md
# Receive Byte-to-Word Packer

This block sits between a receive MAC and a receive FIFO. It takes one byte per accepted cycle, marked with start-of-frame and end-of-frame flags, and gathers those bytes into 32-bit words. Each word is presented for one cycle with a strobe, a four-bit byte-valid mask and an end-of-frame flag. A register stage sits between the byte input and the word output.

Two static configuration inputs set the packing. The endianness select chooses how successive bytes map onto byte lanes. The offset enable makes the first word of every frame start two byte positions in, so that word holds only two bytes. With the offset, the payload that follows lands on a 32-bit boundary in host memory. The final word of a frame may be partly filled. Unused lanes always carry zero and have their mask bit cleared.

Top module: `rx_word_packer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `out_valid`, `out_eof`, `out_bvalid` and `out_word` all zero.
- R2: In little-endian mode (`cfg_big_endian`=0) without offset, the k-th byte of a word (k=0..3) lands in bits [8k+7:8k]. A word is emitted after its fourth byte with `out_bvalid`=4'b1111. Mask bit i flags bits [8i+7:8i].
- R3: In big-endian mode (`cfg_big_endian`=1) without offset, the k-th byte of a word lands in bits [31-8k:24-8k].
- R4: In little-endian mode with `cfg_offset_en`=1, the first word of a frame carries its two bytes in bits [31:16], first byte in [23:16], mask 4'b1100.
- R5: In big-endian mode with `cfg_offset_en`=1, the first word of a frame carries its two bytes in bits [15:0], first byte in [15:8], mask 4'b0011.
- R6: Words after the first that are not the last of the frame carry mask 4'b1111 and `out_eof`=0.
- R7: The word holding the byte flagged `in_eof` is emitted with `out_eof`=1, even if partly filled. Its mask marks exactly the bytes received since the previous word.
- R8: In offset mode, a one-byte frame yields a single word with one valid byte in the first offset position (lane 2 little-endian, lane 1 big-endian) and `out_eof`=1.
- R9: Every byte lane whose mask bit is clear reads zero whenever `out_valid` is high.
- R10: After an end-of-frame, the next byte is the first of a new frame and again receives the first-word placement, even with no idle cycle between frames.
- R11: `out_valid` pulses for exactly the one cycle after the byte that completes a word. Cycles with `in_valid` low neither emit a word nor disturb the bytes gathered so far.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_offset_en | input | 1 | 1: first word of each frame starts two byte positions in |
| cfg_big_endian | input | 1 | 1: big-endian lane order, 0: little-endian |
| in_valid | input | 1 | A byte is presented this cycle |
| in_byte | input | 8 | Received byte |
| in_sof | input | 1 | This byte is the first of a frame |
| in_eof | input | 1 | This byte is the last of a frame |
| out_valid | output | 1 | Word strobe, one cycle per word |
| out_word | output | 32 | Packed word |
| out_bvalid | output | 4 | Per-lane valid flags, bit i for bits [8i+7:8i] |
| out_eof | output | 1 | Word is the last of its frame |

## Verification
Every word appears exactly one cycle after the byte that completes it, whether that is the fourth byte or the end-of-frame byte. The reset values also appear one cycle after the reset edge. The bench drives inputs on the falling edge and samples outputs on the next falling edge, which falls half a period after the edge that registers the byte. A monitor collects every strobed word in order. The scenarios compare the collected list against expected words worked out by hand from the lane rules. The timing scenario samples `out_valid` after each single byte to confirm it rises only after the completing byte and drops one cycle later.

// File: rtl/rxp_pkg.sv
// Package: shared constants for the receive word packer.
// Assumes byte-wide input and a word width that is a multiple of a byte.
package rxp_pkg;
    // Lane ordering selector values.
    typedef enum logic {
        ORDER_LITTLE = 1'b0,
        ORDER_BIG    = 1'b1
    } lane_order_e;

    localparam int unsigned BYTE_BITS = 8;
endpackage

// File: rtl/rxp_slot_ctrl.sv
// Module: rxp_slot_ctrl
// Tracks the next byte position (slot) within the word being gathered and
// whether a frame is open. Slot 0 is the first byte of a word in arrival
// order. Assumes at most one byte per cycle.
module rxp_slot_ctrl #(
    parameter int unsigned LANES     = 4,
    parameter int unsigned START_OFS = 2,
    localparam int unsigned SLOT_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_offset_en,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic [SLOT_W-1:0] cur_slot,
    output logic              first_byte,
    output logic              word_done
);
    localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(LANES - 1);
    localparam logic [SLOT_W-1:0] OFFSET_POS = SLOT_W'(START_OFS);

    logic [SLOT_W-1:0] slot_q;
    logic              in_frame_q;
    logic [SLOT_W-1:0] start_slot;

    // Decide where the current byte goes and whether it closes a word.
    always_comb begin
        first_byte = in_sof | ~in_frame_q;
        start_slot = cfg_offset_en ? OFFSET_POS : '0;
        cur_slot   = first_byte ? start_slot : slot_q;
        word_done  = in_valid & ((cur_slot == LAST_SLOT) | in_eof);
    end

    // Advance the slot and frame-open flag on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q     <= '0;
            in_frame_q <= 1'b0;
        end else if (in_valid) begin
            in_frame_q <= ~in_eof;
            slot_q     <= (cur_slot == LAST_SLOT) ? '0 : cur_slot + 1'b1;
        end
    end
endmodule

// File: rtl/rxp_lane_map.sv
// Module: rxp_lane_map
// Converts a byte slot into a one-hot byte lane select. Little order puts
// slot k on lane k; big order puts slot k on lane LANES-1-k. Purely
// combinational.
module rxp_lane_map #(
    parameter int unsigned LANES   = 4,
    localparam int unsigned SLOT_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic              big_order,
    output logic [LANES-1:0]  lane_sel
);
    // One comparator pair per lane.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [SLOT_W-1:0] LE_SLOT = SLOT_W'(i);
        localparam logic [SLOT_W-1:0] BE_SLOT = SLOT_W'(LANES - 1 - i);
        assign lane_sel[i] = big_order ? (slot == BE_SLOT) : (slot == LE_SLOT);
    end
endmodule

// File: rtl/rxp_accum.sv
// Module: rxp_accum
// Holds the partly gathered word and its lane mask, merges each new byte
// into its lane and registers the finished word for one strobe cycle.
// Assumes lane_sel is one-hot whenever in_valid is high.
module rxp_accum #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned WORD_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_eof,
    input  logic [LANES-1:0]  lane_sel,
    input  logic              first_byte,
    input  logic              word_done,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic [LANES-1:0]  out_bvalid,
    output logic              out_eof
);
    logic [WORD_W-1:0] acc_data_q;
    logic [LANES-1:0]  acc_mask_q;
    logic [WORD_W-1:0] base_data;
    logic [LANES-1:0]  base_mask;
    logic [WORD_W-1:0] merged_data;
    logic [LANES-1:0]  merged_mask;

    // A frame's first byte starts from an empty word.
    always_comb begin
        base_data   = first_byte ? '0 : acc_data_q;
        base_mask   = first_byte ? '0 : acc_mask_q;
        merged_mask = base_mask | lane_sel;
    end

    // Drop the incoming byte into its selected lane.
    for (genvar i = 0; i < LANES; i++) begin : g_merge
        assign merged_data[i*BYTE_W +: BYTE_W] =
            lane_sel[i] ? in_byte : base_data[i*BYTE_W +: BYTE_W];
    end

    // Gather bytes and present each finished word for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_data_q <= '0;
            acc_mask_q <= '0;
            out_valid  <= 1'b0;
            out_word   <= '0;
            out_bvalid <= '0;
            out_eof    <= 1'b0;
        end else begin
            out_valid <= word_done;
            out_eof   <= word_done & in_eof;
            if (word_done) begin
                out_word   <= merged_data;
                out_bvalid <= merged_mask;
                acc_data_q <= '0;
                acc_mask_q <= '0;
            end else if (in_valid) begin
                acc_data_q <= merged_data;
                acc_mask_q <= merged_mask;
            end
        end
    end
endmodule

// File: rtl/rx_word_packer.sv
// Module: rx_word_packer
// Top of the receive packer: byte stream with frame markers in, words with
// per-lane valid flags and end-of-frame out, one register stage of latency.
// Assumes configuration inputs change only between frames.
module rx_word_packer #(
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned BYTE_W       = rxp_pkg::BYTE_BITS,
    parameter int unsigned OFFSET_BYTES = 2,
    localparam int unsigned LANES       = DATA_W / BYTE_W,
    localparam int unsigned SLOT_W      = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_offset_en,
    input  logic              cfg_big_endian,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_word,
    output logic [LANES-1:0]  out_bvalid,
    output logic              out_eof
);
    import rxp_pkg::*;

    logic [SLOT_W-1:0] cur_slot;
    logic              first_byte;
    logic              word_done;
    logic [LANES-1:0]  lane_sel;
    lane_order_e       order;

    // Name the endianness select as a lane order.
    always_comb order = lane_order_e'(cfg_big_endian);

    rxp_slot_ctrl #(
        .LANES     (LANES),
        .START_OFS (OFFSET_BYTES)
    ) u_slot (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_offset_en (cfg_offset_en),
        .in_valid      (in_valid),
        .in_sof        (in_sof),
        .in_eof        (in_eof),
        .cur_slot      (cur_slot),
        .first_byte    (first_byte),
        .word_done     (word_done)
    );

    rxp_lane_map #(
        .LANES (LANES)
    ) u_map (
        .slot      (cur_slot),
        .big_order (order == ORDER_BIG),
        .lane_sel  (lane_sel)
    );

    rxp_accum #(
        .LANES  (LANES),
        .BYTE_W (BYTE_W)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .in_eof     (in_eof),
        .lane_sel   (lane_sel),
        .first_byte (first_byte),
        .word_done  (word_done),
        .out_valid  (out_valid),
        .out_word   (out_word),
        .out_bvalid (out_bvalid),
        .out_eof    (out_eof)
    );
endmodule

// File: rtl/rxp_checker.sv
// Module: rxp_checker
// Port-level properties of the packer, bound onto every rx_word_packer.
module rxp_checker #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned WORD_W = LANES * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_offset_en,
    input logic              in_valid,
    input logic              in_eof,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_word,
    input logic [LANES-1:0]  out_bvalid,
    input logic              out_eof
);
    logic [WORD_W-1:0] mask_bits;

    // Widen the lane mask to a bit mask.
    for (genvar i = 0; i < LANES; i++) begin : g_bits
        assign mask_bits[i*BYTE_W +: BYTE_W] = {BYTE_W{out_bvalid[i]}};
    end

    // R9
    unused_lanes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_word & ~mask_bits) == '0));

    // R11
    no_word_without_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7
    eof_word_emitted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eof) |=> (out_valid && out_eof));

    // R7
    eof_only_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> out_valid);

    // R11
    word_has_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_bvalid != '0));

    // R6
    short_non_last_is_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eof && ($countones(out_bvalid) != LANES))
            |-> (cfg_offset_en && ($countones(out_bvalid) == 2)));
endmodule

bind rx_word_packer rxp_checker #(
    .LANES  (LANES),
    .BYTE_W (BYTE_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_offset_en (cfg_offset_en),
    .in_valid      (in_valid),
    .in_eof        (in_eof),
    .out_valid     (out_valid),
    .out_word      (out_word),
    .out_bvalid    (out_bvalid),
    .out_eof       (out_eof)
);

// File: tb/sim_rx_word_packer.sv
// Bench: directed scenarios, each task checks its own collected words.
module sim_rx_word_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_offset_en = 1'b0;
    logic        cfg_big_endian = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic        out_valid;
    logic [31:0] out_word;
    logic [3:0]  out_bvalid;
    logic        out_eof;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] got_word [0:15];
    logic [3:0]  got_mask [0:15];
    logic        got_eof  [0:15];
    int          got_n = 0;

    always #10 clk = ~clk;

    rx_word_packer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_offset_en(cfg_offset_en),
        .cfg_big_endian(cfg_big_endian), .in_valid(in_valid), .in_byte(in_byte),
        .in_sof(in_sof), .in_eof(in_eof), .out_valid(out_valid),
        .out_word(out_word), .out_bvalid(out_bvalid), .out_eof(out_eof)
    );

    // Collect every strobed word, sampled at the falling edge.
    always @(negedge clk) begin
        if (out_valid && got_n < 16) begin
            got_word[got_n] = out_word;
            got_mask[got_n] = out_bvalid;
            got_eof[got_n]  = out_eof;
            got_n = got_n + 1;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic sof, input logic eof);
        in_valid = 1'b1; in_byte = b; in_sof = sof; in_eof = eof;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_byte = 8'h00;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Send bytes base, base+0x11, ... as one frame.
    task automatic frame(input int len, input logic [7:0] first, input int gap);
        for (int i = 0; i < len; i++) begin
            send(first + 8'(i * 8'h11), i == 0, i == len - 1);
            if (gap > 0 && i != len - 1) idle(gap);
        end
    endtask

    task automatic expect_word(input string req, input int idx, input logic [31:0] w,
                               input logic [3:0] m, input logic e);
        check(req, {32'h0, got_word[idx]}, {32'h0, w});
        check(req, {60'h0, got_mask[idx]}, {60'h0, m});
        check(req, {63'h0, got_eof[idx]},  {63'h0, e});
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        idle(2);
        check("R1", {28'h0, out_valid, out_eof, 2'b0, out_bvalid, out_word}, 64'h0);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic t_le_plain;
        cfg_offset_en = 0; cfg_big_endian = 0; got_n = 0;
        frame(6, 8'h11, 0); idle(2);
        check("R2 count", 64'(got_n), 64'd2);
        expect_word("R2", 0, 32'h44332211, 4'b1111, 0);
        expect_word("R7 R9", 1, 32'h00006655, 4'b0011, 1);
    endtask

    task automatic t_be_plain;
        cfg_offset_en = 0; cfg_big_endian = 1; got_n = 0;
        frame(6, 8'h11, 2); idle(2);
        check("R3 count", 64'(got_n), 64'd2);
        expect_word("R3 R11", 0, 32'h11223344, 4'b1111, 0);
        expect_word("R7 R9", 1, 32'h55660000, 4'b1100, 1);
    endtask

    task automatic t_le_offset;
        cfg_offset_en = 1; cfg_big_endian = 0; got_n = 0;
        frame(7, 8'h11, 0); idle(2);
        check("R4 count", 64'(got_n), 64'd3);
        expect_word("R4", 0, 32'h22110000, 4'b1100, 0);
        expect_word("R6", 1, 32'h66554433, 4'b1111, 0);
        expect_word("R7", 2, 32'h00000077, 4'b0001, 1);
    endtask

    task automatic t_be_offset;
        cfg_offset_en = 1; cfg_big_endian = 1; got_n = 0;
        frame(6, 8'h11, 1); idle(2);
        check("R5 count", 64'(got_n), 64'd2);
        expect_word("R5", 0, 32'h00001122, 4'b0011, 0);
        expect_word("R6 R7", 1, 32'h33445566, 4'b1111, 1);
    endtask

    task automatic t_short;
        cfg_offset_en = 1; cfg_big_endian = 0; got_n = 0;
        send(8'hAA, 1, 1); idle(2);
        cfg_big_endian = 1;
        send(8'hBB, 1, 1); idle(2);
        check("R8 count", 64'(got_n), 64'd2);
        expect_word("R8 le", 0, 32'h00AA0000, 4'b0100, 1);
        expect_word("R8 be", 1, 32'h0000BB00, 4'b0010, 1);
    endtask

    task automatic t_back_to_back;
        cfg_offset_en = 1; cfg_big_endian = 0; got_n = 0;
        frame(3, 8'h10, 0);
        frame(3, 8'h50, 0); idle(2);
        check("R10 count", 64'(got_n), 64'd4);
        expect_word("R10", 0, 32'h21100000, 4'b1100, 0);
        expect_word("R10", 1, 32'h00000032, 4'b0001, 1);
        expect_word("R10", 2, 32'h61500000, 4'b1100, 0);
        expect_word("R10", 3, 32'h00000072, 4'b0001, 1);
    endtask

    task automatic t_timing;
        cfg_offset_en = 0; cfg_big_endian = 0; got_n = 0;
        send(8'h01, 1, 0);
        check("R11 b1", 64'(out_valid), 64'd0);
        idle(3);
        check("R11 idle", 64'(out_valid), 64'd0);
        send(8'h02, 0, 0);
        send(8'h03, 0, 0);
        check("R11 b3", 64'(out_valid), 64'd0);
        send(8'h04, 0, 0);
        check("R11 b4", 64'(out_valid), 64'd1);
        idle(1);
        check("R11 pulse", 64'(out_valid), 64'd0);
        send(8'h05, 0, 1);
        check("R11 eof", 64'(out_valid), 64'd1);
        idle(1);
        expect_word("R11 data", 0, 32'h04030201, 4'b1111, 0);
        expect_word("R7 single", 1, 32'h00000005, 4'b0001, 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_le_plain();
        t_be_plain();
        t_le_offset();
        t_be_offset();
        t_short();
        t_back_to_back();
        t_timing();
        t_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule